// File: doc/BRIEF.md
# Descending In-Place Memory Sorter

This block owns a small word memory and, once a capture phase ends, rearranges the stored words so that the largest value sits at address 0 and the smallest at the last address. The capture phase is marked by a level input. While it is high, the block is idle and an upstream stage fills the memory through a host port. When the level falls, sorting begins on its own. The host port is also how a downstream serial stage reads the result once the done pulse has fired.

Sorting happens in place. It uses a single memory port, one access per clock, with a synchronous read and one cycle of latency. Two holding registers keep the pair under comparison. The order of work is a fixed bubble sort: DEPTH-1 passes, each over DEPTH-1 adjacent pairs. A pair is written back swapped only when the lower-addressed word is strictly smaller than the one above it. Because of this, the run time follows directly from the number of ascending pairs in the input. While a sort runs, a four-bit status output shows a single lit bit.

Top module: `inplace_desc_sorter`

## Requirements
- R1: A high-to-low transition of `capture_i` seen while idle starts a sort, and `busy_o` is high from the next rising edge onward. A level that stays high or low, or a low-to-high transition, starts nothing.
- R2: When `done_o` fires, the memory read through the host port holds the original multiset of words in non-increasing order, with the largest word at address 0.
- R3: Equal words are never exchanged. With DEPTH=8, `done_o` is high exactly 245 + 2*K cycles after the start edge, where K is the number of address pairs i<j with word[i] < word[j] strictly. The cycle right after the start edge counts as cycle 0.
- R4: `done_o` is high for exactly one cycle. In the cycle after it, `busy_o` is low.
- R5: `led_o` equals 4'b1000 (only bit 3 set) whenever `busy_o` is high, and 4'b0000 otherwise.
- R6: A fall of `capture_i` that occurs while a sort is running is ignored. It neither restarts the sort, nor changes its duration, nor starts a new sort after `done_o`.
- R7: Host writes presented while `busy_o` is high have no effect on the memory.
- R8: While idle, `host_rdata_o` shows the word at `host_addr_i` one clock edge after the address is presented. A write with `host_we_i` high stores `host_wdata_i` at `host_addr_i`.
- R9: After reset, `busy_o`, `done_o` and `led_o` are zero, and every memory word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| capture_i | input | 1 | Capture-phase level; its falling edge starts a sort |
| host_we_i | input | 1 | Host write enable, honoured only while idle |
| host_addr_i | input | AW | Host word address |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Registered read data for the host address |
| busy_o | output | 1 | Sort in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sort |
| led_o | output | LED_W | Status pattern, only bit BUSY_LED lit while sorting |

## Verification
The bench builds the block with its defaults: eight words of four bits and a four-bit status output. With only sixteen values per word, duplicates are common, so the strict-compare rule is exercised on almost every vector. The bench computes the expected order by counting occurrences per value. It computes the exact done cycle from the count of strictly ascending pairs, so a swap of equal words or a missing swap shows up as a timing error even when the final order looks right. Fixed patterns (all equal, ascending, descending, alternating) are run along with about a hundred pseudorandom vectors. Host writes and a second capture fall are injected mid-sort.

// File: rtl/sort_pkg.sv
package sort_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_A,
    ST_WT_A,
    ST_RD_B,
    ST_WT_B,
    ST_CMP,
    ST_WR_A,
    ST_WR_B,
    ST_DONE
  } sort_state_e;

  function automatic int addr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/sort_fall_det.sv
module sort_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);

  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign fall_o = lvl_q & ~lvl_i;

endmodule

// File: rtl/sort_ram.sv
module sort_ram #(
  parameter int DEPTH = 8,
  parameter int DW    = 4,
  parameter int AW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      rdata_q <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;

  AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (int'(addr_i) < DEPTH)); // R8

endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
  import sort_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 4,
  parameter int AW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 2);

  sort_state_e   state_q, state_d;
  logic [AW-1:0] idx_q, pass_q;
  logic [DW-1:0] a_q, b_q;
  logic          swap_w, step_w, last_w;

  assign swap_w = a_q < b_q;  // strict: equal words stay put
  assign step_w = (state_q == ST_CMP && !swap_w) || (state_q == ST_WR_B);
  assign last_w = step_w && (idx_q == LAST) && (pass_q == LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RD_A;
      ST_RD_A: state_d = ST_WT_A;
      ST_WT_A: state_d = ST_RD_B;
      ST_RD_B: state_d = ST_WT_B;
      ST_WT_B: state_d = ST_CMP;
      ST_CMP:  state_d = swap_w ? ST_WR_A : (last_w ? ST_DONE : ST_RD_A);
      ST_WR_A: state_d = ST_WR_B;
      ST_WR_B: state_d = last_w ? ST_DONE : ST_RD_A;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      pass_q <= '0;
    end else if (state_q == ST_IDLE) begin
      idx_q  <= '0;
      pass_q <= '0;
    end else if (step_w) begin
      if (idx_q == LAST) begin
        idx_q <= '0;
        if (pass_q != LAST) pass_q <= pass_q + AW'(1);
      end else begin
        idx_q <= idx_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (state_q == ST_WT_A) a_q <= mem_rdata_i;
      if (state_q == ST_WT_B) b_q <= mem_rdata_i;
    end
  end

  always_comb begin
    mem_addr_o  = idx_q;
    mem_we_o    = 1'b0;
    mem_wdata_o = b_q;
    unique case (state_q)
      ST_RD_B: mem_addr_o = idx_q + AW'(1);
      ST_WR_A: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = b_q;
      end
      ST_WR_B: begin
        mem_addr_o  = idx_q + AW'(1);
        mem_we_o    = 1'b1;
        mem_wdata_o = a_q;
      end
      default: ;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_DONE_THEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R4
  AST_SWAP_STRICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR_A) |-> (a_q < b_q)); // R3
  AST_INDEX_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q <= LAST) && (pass_q <= LAST)); // R2
  AST_WRITE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR_A) |=> mem_we_o && (mem_addr_o == $past(mem_addr_o) + AW'(1))); // R2

endmodule

// File: rtl/inplace_desc_sorter.sv
module inplace_desc_sorter
  import sort_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int DW       = 4,
  parameter int LED_W    = 4,
  parameter int BUSY_LED = 3,
  localparam int AW      = addr_bits(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             host_we_i,
  input  logic [AW-1:0]    host_addr_i,
  input  logic [DW-1:0]    host_wdata_i,
  output logic [DW-1:0]    host_rdata_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [LED_W-1:0] led_o
);

  logic          fall_w, busy_w, done_w;
  logic [AW-1:0] ctl_addr_w, ram_addr_w;
  logic          ctl_we_w, ram_we_w;
  logic [DW-1:0] ctl_wdata_w, ram_wdata_w, ram_rdata_w;

  sort_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (capture_i),
    .fall_o (fall_w)
  );

  sort_ctrl #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (fall_w),
    .busy_o      (busy_w),
    .done_o      (done_w),
    .mem_addr_o  (ctl_addr_w),
    .mem_we_o    (ctl_we_w),
    .mem_wdata_o (ctl_wdata_w),
    .mem_rdata_i (ram_rdata_w)
  );

  // host owns the port only while idle
  assign ram_addr_w  = busy_w ? ctl_addr_w  : host_addr_i;
  assign ram_we_w    = busy_w ? ctl_we_w    : host_we_i;
  assign ram_wdata_w = busy_w ? ctl_wdata_w : host_wdata_i;

  sort_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ram_we_w),
    .addr_i  (ram_addr_w),
    .wdata_i (ram_wdata_w),
    .rdata_o (ram_rdata_w)
  );

  for (genvar g = 0; g < LED_W; g++) begin : g_led
    if (g == BUSY_LED) begin : g_on
      assign led_o[g] = busy_w;
    end else begin : g_off
      assign led_o[g] = 1'b0;
    end
  end

  assign host_rdata_o = ram_rdata_w;
  assign busy_o       = busy_w;
  assign done_o       = done_w;

  AST_START_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_w && !busy_w) |=> busy_w); // R1
  AST_NO_SPURIOUS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_w && !busy_w) |=> !busy_w); // R1
  AST_HOST_WRITE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_w && ram_we_w) |-> ctl_we_w); // R7

endmodule

// File: tb/inplace_desc_sorter_tb.sv
module inplace_desc_sorter_tb;

  localparam int DEPTH = 8;
  localparam int DW    = 4;
  localparam int AW    = 3;
  localparam int BASE  = 5 * (DEPTH - 1) * (DEPTH - 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          capture_i = 1'b0;
  logic          host_we_i = 1'b0;
  logic [AW-1:0] host_addr_i = '0;
  logic [DW-1:0] host_wdata_i = '0;
  logic [DW-1:0] host_rdata_o;
  logic          busy_o, done_o;
  logic [3:0]    led_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  inplace_desc_sorter u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .capture_i    (capture_i),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .led_o        (led_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic host_write(input int a, input int v);
    @(negedge clk);
    host_we_i    = 1'b1;
    host_addr_i  = AW'(a);
    host_wdata_i = DW'(v);
    @(negedge clk);
    host_we_i    = 1'b0;
  endtask

  task automatic host_read(input int a, output int v);
    @(negedge clk);
    host_addr_i = AW'(a);
    @(negedge clk);
    v = int'(host_rdata_o);
  endtask

  task automatic run_sort(input int vals[DEPTH], input bit inject);
    int exp[DEPTH];
    int hist[16];
    int inv, k, cnt, rd;
    bit seen;
    foreach (hist[i]) hist[i] = 0;
    inv = 0;
    for (int i = 0; i < DEPTH; i++) begin
      hist[vals[i]]++;
      for (int j = i + 1; j < DEPTH; j++) if (vals[i] < vals[j]) inv++;
    end
    k = 0;
    for (int v = 15; v >= 0; v--)
      for (int n = 0; n < hist[v]; n++) begin exp[k] = v; k++; end

    @(negedge clk);
    capture_i = 1'b1;
    for (int i = 0; i < DEPTH; i++) host_write(i, vals[i]);
    @(negedge clk);
    chk(!busy_o, "R1 no start while capture high", int'(busy_o), 0);
    chk(led_o == 4'b0000, "R5 idle led", int'(led_o), 0);
    capture_i = 1'b0;
    @(posedge clk);
    cnt  = 0;
    seen = 1'b0;
    while (cnt < 2000) begin
      @(negedge clk);
      if (cnt == 0) chk(busy_o, "R1 busy after fall", int'(busy_o), 1);
      if (busy_o) chk(led_o == 4'b1000, "R5 busy led", int'(led_o), 8);
      if (done_o) begin seen = 1'b1; break; end
      if (inject) begin
        if (cnt == 40) begin
          host_we_i = 1'b1; host_addr_i = '0; host_wdata_i = 4'hF;
        end
        if (cnt == 41) begin
          host_we_i = 1'b0; host_addr_i = 3'd7; host_wdata_i = 4'hF;
        end
        if (cnt == 42) host_we_i = 1'b1;
        if (cnt == 43) host_we_i = 1'b0;
        if (cnt == 60) capture_i = 1'b1;
        if (cnt == 70) capture_i = 1'b0;
      end
      cnt++;
    end
    chk(seen, "R3 done reached", cnt, BASE + 2 * inv);
    chk(cnt == BASE + 2 * inv, inject ? "R6 duration unchanged" : "R3 done cycle",
        cnt, BASE + 2 * inv);
    @(negedge clk);
    chk(!done_o, "R4 done one cycle", int'(done_o), 0);
    chk(!busy_o, "R4 idle after done", int'(busy_o), 0);
    chk(led_o == 4'b0000, "R5 led after done", int'(led_o), 0);
    if (inject) begin
      repeat (5) @(negedge clk);
      chk(!busy_o, "R6 no restart", int'(busy_o), 0);
    end
    for (int i = 0; i < DEPTH; i++) begin
      host_read(i, rd);
      chk(rd == exp[i], inject ? "R7 write during sort ignored" : "R2 sorted word",
          rd, exp[i]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v[DEPTH];
    int rd;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o, "R9 reset outputs", int'(busy_o) + int'(done_o), 0);
    chk(led_o == 4'b0000, "R9 reset led", int'(led_o), 0);
    rst_ni = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      host_read(i, rd);
      chk(rd == 0, "R9 memory cleared", rd, 0);
    end
    host_write(5, 9);
    host_read(5, rd);
    chk(rd == 9, "R8 host write/read", rd, 9);
    repeat (4) @(negedge clk);
    chk(!busy_o, "R1 idle without fall", int'(busy_o), 0);

    foreach (v[i]) v[i] = 7;               run_sort(v, 1'b0);
    foreach (v[i]) v[i] = i;               run_sort(v, 1'b0);
    foreach (v[i]) v[i] = 15 - i;          run_sort(v, 1'b0);
    foreach (v[i]) v[i] = (i % 2) ? 15 : 0; run_sort(v, 1'b0);
    foreach (v[i]) v[i] = i * 2;           run_sort(v, 1'b1);

    lfsr = 16'hACE1;
    for (int n = 0; n < 100; n++) begin
      for (int i = 0; i < DEPTH; i++) begin
        for (int s = 0; s < 4; s++)
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        v[i] = int'(lfsr[3:0]);
      end
      run_sort(v, (n % 10) == 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule